// File: doc/BRIEF.md
# Low-Power State Sequencer

This block decides which clocks of a small 8-bit controller core are running. Software can ask for one of two low-power states. In the light sleep state the CPU clock stops while the peripheral clock keeps running. In the deep sleep state both clocks stop and the oscillator is switched off. The block also filters the external reset pin and produces the internal reset. It sequences the way out of each sleep state.

A light sleep ends on any enabled interrupt or on a hardware reset. If a reset ends it, the CPU clock comes back while the reset pin is being qualified. During that window internal RAM writes are blocked and port writes are not. A deep sleep ends only through a hardware reset. A reset pin held high restarts the oscillator. Once the oscillator reports that it is running, the pin is qualified and the internal reset is held until the oscillator is stable and the pin has been released. RAM writes stay blocked during reset, so RAM contents survive.

Top module: `lpm_ctrl`

## Requirements
- R1: While `por_n` is low the block is in the reset-wait state: `state_o`=3, `int_rst`=1, `ram_wr_inhibit`=1. The state codes are run=0, light sleep=1, deep sleep=2, reset-wait=3. After `por_n` rises, the block moves to run once `rst_pin` is low and `osc_run` is high.
- R2: A pin reset is recognised only after `rst_pin` and `osc_run` have both stayed high across RST_CYC (2) `mc_tick` pulses. A shorter pulse, or a pin held high while `osc_run` is low, leaves the state unchanged.
- R3: A `req_idle` pulse in run gives state 1 on the next cycle, with `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R4: In state 1, `irq_pend` returns the block to run on the next cycle, and `cpu_clk_en` goes back to 1.
- R5: In state 1 with `rst_pin` high, and before the reset is recognised, `cpu_clk_en`=1, `ram_wr_inhibit`=1 and `int_rst`=0. Once the reset is recognised the state becomes 3.
- R6: A `req_pdown` pulse in run gives state 2 on the next cycle, with `cpu_clk_en`, `per_clk_en` and `osc_en` all 0.
- R7: When `req_idle` and `req_pdown` arrive in the same cycle, the block enters state 2.
- R8: In state 2, `irq_pend`, `req_idle` and `req_pdown` have no effect. `rst_pin` high sets `osc_en`=1, and a qualified reset moves the block to state 3.
- R9: State 3 is held while `osc_run` is low, even with `rst_pin` low. It leaves to run only when `rst_pin` is low and `osc_run` is high.
- R10: `ram_wr_inhibit` is 0 in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low |
| mc_tick | input | 1 | One-cycle pulse per machine cycle |
| rst_pin | input | 1 | Raw external reset pin, active high |
| osc_run | input | 1 | Oscillator running and stable |
| req_idle | input | 1 | Software request for light sleep |
| req_pdown | input | 1 | Software request for deep sleep |
| irq_pend | input | 1 | Any enabled interrupt is pending |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Internal reset |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| state_o | output | 2 | Current state code |

## Verification
The assertions check the following on every cycle:
- deep sleep is left only for reset-wait;
- reset-wait cannot be entered while the pin is low;
- reset-wait holds while the oscillator is not running;
- an interrupt ends light sleep;
- a deep-sleep request wins in run.

Only the bench scenarios can show the rest:
- the tick count the filter needs, and the rejection of short pulses;
- the clock and RAM-inhibit levels during the reset window out of light sleep;
- the restart of the oscillator from deep sleep.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int RST_CYC = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       mc_tick,
  input  logic       rst_pin,
  input  logic       osc_run,
  input  logic       req_idle,
  input  logic       req_pdown,
  input  logic       irq_pend,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       int_rst,
  output logic       ram_wr_inhibit,
  output logic [1:0] state_o
);

  localparam int CW = $clog2(RST_CYC + 1);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_IDLE = 2'd1, S_PDN = 2'd2, S_RSTW = 2'd3} st_t;

  st_t           state, nxt;
  logic [CW-1:0] cnt;
  logic          rst_seen;

  assign rst_seen = (cnt == CW'(RST_CYC));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 cnt <= '0;
    else if (!rst_pin || !osc_run) cnt <= '0;
    else if (mc_tick && !rst_seen) cnt <= cnt + 1'b1;
  end

  always_comb begin
    nxt = state;
    if (rst_seen) nxt = S_RSTW;
    else begin
      case (state)
        S_RUN:   if (req_pdown) nxt = S_PDN;
                 else if (req_idle) nxt = S_IDLE;
        S_IDLE:  if (irq_pend) nxt = S_RUN;
        S_PDN:   nxt = S_PDN;
        S_RSTW:  if (!rst_pin && osc_run) nxt = S_RUN;
        default: nxt = S_RSTW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state <= S_RSTW;
    else        state <= nxt;
  end

  assign state_o        = state;
  assign int_rst        = (state == S_RSTW);
  assign per_clk_en     = (state != S_PDN);
  assign osc_en         = (state != S_PDN) || rst_pin;
  assign cpu_clk_en     = (state == S_RUN) || (state == S_RSTW) || ((state == S_IDLE) && rst_pin);
  assign ram_wr_inhibit = (state == S_RSTW) || ((state == S_IDLE) && rst_pin);

  assert_pdown_exit_R8: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_PDN) |=> (state == S_PDN || state == S_RSTW));

  assert_no_rst_when_pin_low_R2: assert property (@(posedge clk) disable iff (!por_n)
    (state != S_RSTW && !rst_pin) |=> (state != S_RSTW));

  assert_rstw_holds_osc_R9: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_RSTW && !osc_run) |=> (state == S_RSTW));

  assert_idle_wake_R4: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_IDLE && irq_pend && !rst_pin) |=> (state == S_RUN && cpu_clk_en));

  assert_pdown_prio_R7: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_RUN && req_pdown && !rst_pin) |=> (state == S_PDN && !osc_en));

endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  logic clk = 1'b0;
  logic por_n, mc_tick, rst_pin, osc_run, req_idle, req_pdown, irq_pend;
  logic cpu_clk_en, per_clk_en, osc_en, int_rst, ram_wr_inhibit;
  logic [1:0] state_o;
  int checks = 0, fails = 0;
  int tcnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpm_ctrl dut (
    .clk(clk), .por_n(por_n), .mc_tick(mc_tick), .rst_pin(rst_pin), .osc_run(osc_run),
    .req_idle(req_idle), .req_pdown(req_pdown), .irq_pend(irq_pend),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .int_rst(int_rst), .ram_wr_inhibit(ram_wr_inhibit), .state_o(state_o)
  );

  always @(negedge clk) begin
    tcnt    <= (tcnt == 3) ? 0 : tcnt + 1;
    mc_tick <= (tcnt == 3);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_idle();
    req_idle = 1'b1; step(1); req_idle = 1'b0;
  endtask

  task automatic t_power_on();
    step(3);
    chk("R1 state in por", state_o, 3);
    chk("R1 int_rst in por", int_rst, 1);
    chk("R1 inhibit in por", ram_wr_inhibit, 1);
    por_n = 1'b1; step(2);
    chk("R1 run after por", state_o, 0);
    chk("R1 int_rst released", int_rst, 0);
    chk("R10 inhibit in run", ram_wr_inhibit, 0);
  endtask

  task automatic t_reset_filter();
    rst_pin = 1'b1; step(3); rst_pin = 1'b0; step(12);
    chk("R2 short pulse ignored", state_o, 0);
    osc_run = 1'b0; rst_pin = 1'b1; step(20);
    chk("R2 no osc no reset", state_o, 0);
    osc_run = 1'b1; step(4);
    chk("R2 one tick not enough", int_rst, 0);
    step(8);
    chk("R2 qualified reset", state_o, 3);
    rst_pin = 1'b0; step(2);
    chk("R9 exit to run", state_o, 0);
  endtask

  task automatic t_idle();
    pulse_idle();
    chk("R3 idle state", state_o, 1);
    chk("R3 cpu clk off", cpu_clk_en, 0);
    chk("R3 per clk on", per_clk_en, 1);
    chk("R3 osc on", osc_en, 1);
    irq_pend = 1'b1; step(1); irq_pend = 1'b0;
    chk("R4 wake to run", state_o, 0);
    chk("R4 cpu clk back", cpu_clk_en, 1);
  endtask

  task automatic t_idle_reset();
    pulse_idle();
    rst_pin = 1'b1; #1;
    chk("R5 still idle", state_o, 1);
    chk("R5 cpu runs on", cpu_clk_en, 1);
    chk("R5 ram blocked", ram_wr_inhibit, 1);
    chk("R5 no int_rst yet", int_rst, 0);
    step(12);
    chk("R5 reset taken", state_o, 3);
    chk("R5 ram still blocked", ram_wr_inhibit, 1);
    rst_pin = 1'b0; step(2);
    chk("R10 inhibit clear in run", ram_wr_inhibit, 0);
  endtask

  task automatic t_pdown();
    req_idle = 1'b1; req_pdown = 1'b1; step(1); req_idle = 1'b0; req_pdown = 1'b0;
    chk("R7 pdown wins", state_o, 2);
    chk("R6 cpu clk off", cpu_clk_en, 0);
    chk("R6 per clk off", per_clk_en, 0);
    chk("R6 osc off", osc_en, 0);
    osc_run = 1'b0;
    irq_pend = 1'b1; req_idle = 1'b1; req_pdown = 1'b1; step(6);
    irq_pend = 1'b0; req_idle = 1'b0; req_pdown = 1'b0;
    chk("R8 irq and requests ignored", state_o, 2);
    chk("R8 osc stays off", osc_en, 0);
    rst_pin = 1'b1; #1;
    chk("R8 pin restarts osc", osc_en, 1);
    step(12);
    chk("R8 waits for osc", state_o, 2);
    osc_run = 1'b1; step(12);
    chk("R8 reset leaves pdown", state_o, 3);
    osc_run = 1'b0; rst_pin = 1'b0; step(5);
    chk("R9 held without osc", state_o, 3);
    chk("R9 int_rst held", int_rst, 1);
    osc_run = 1'b1; step(2);
    chk("R9 run after osc", state_o, 0);
  endtask

  initial begin
    por_n = 1'b0; rst_pin = 1'b0; osc_run = 1'b1;
    req_idle = 1'b0; req_pdown = 1'b0; irq_pend = 1'b0;
    t_power_on();
    t_reset_filter();
    t_idle();
    t_idle_reset();
    t_pdown();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule